// File: doc/BRIEF.md
# Hybrid Lookahead Adder-Subtractor

This block is a purely combinational two's complement adder and subtractor. It is intended for the integer datapath of a processor. Each operand bit forms a generate term and a propagate term. Inside each fixed-width group, every carry is computed as a flat sum-of-products of those terms and the group's carry-in, so no carry ripples bit by bit within the group. Each group passes its carry-out to the next group as an ordinary ripple carry. This trades logic depth against gate count in a way the group size parameter controls.

A single mode bit selects the operation. When the mode bit is set, every bit of the second operand is inverted, and the same bit is fed in as the adder's carry-in. The adder then forms x + ~y + 1, which is x - y. The same adder path serves both operations.

Alongside the result, the block produces a carry-out, an unsigned overflow flag, a signed overflow flag, a zero flag and a negative flag. A status register would capture these as condition codes. The data width must be a whole multiple of the group width.

Top module: `hla_addsub`

## Requirements
- R1: With sub_i = 0, res_o equals (x_i + y_i) mod 2^DATA_W.
- R2: With sub_i = 1, res_o equals (x_i - y_i) mod 2^DATA_W.
- R3: carry_o is bit DATA_W of the (DATA_W+1)-bit sum x_i + (y_i XOR {DATA_W{sub_i}}) + sub_i. When subtracting, carry_o = 1 means no borrow occurred.
- R4: ovf_u_o is 1 when the unsigned result does not fit in DATA_W bits. When adding, it equals carry_o. When subtracting, it equals NOT carry_o, which is the case exactly when x_i < y_i as unsigned numbers.
- R5: ovf_s_o is 1 exactly when the two's complement result is out of range. This happens when x_i and the effective second operand (y_i when adding, ~y_i when subtracting) share a sign bit and res_o has the other sign bit.
- R6: zero_o is 1 exactly when every bit of res_o is 0.
- R7: neg_o equals bit DATA_W-1 of res_o.
- R8: A carry generated in any bit propagates correctly across every group boundary. For example, all-ones plus one gives res_o = 0 with carry_o = 1.
- R9: Subtracting an operand from itself gives res_o = 0, zero_o = 1, carry_o = 1 and ovf_u_o = 0. Subtracting zero leaves x_i unchanged, with carry_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | DATA_W | First operand |
| y_i | input | DATA_W | Second operand |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| res_o | output | DATA_W | Sum or difference |
| carry_o | output | 1 | Carry out of the most significant bit |
| ovf_u_o | output | 1 | Unsigned overflow (carry when adding, borrow when subtracting) |
| ovf_s_o | output | 1 | Two's complement overflow |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result sign bit |

## Verification
The block holds no state, so an internal fault shows up at the ports in the same cycle the operands are applied. A wrong lookahead term corrupts res_o only for operand patterns that exercise the faulty generate or propagate product. Long propagate runs that cross group boundaries are therefore driven on purpose, as well as random operands. A fault in the flag logic appears as a mismatch on the sign, carry and overflow outputs at the range limits. These include the most negative value, all-ones, and equal operands in subtraction.

// File: rtl/hla_pkg.sv
package hla_pkg;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned GRP_W_DEF  = 4;

  typedef struct packed {
    logic zero;
    logic neg;
    logic ovf_s;
    logic ovf_u;
  } flags_t;
endpackage

// File: rtl/hla_opnd_mux.sv
module hla_opnd_mux #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] y_i,
  input  logic         inv_i,
  output logic [W-1:0] q_o
);
  assign q_o = y_i ^ {W{inv_i}};
endmodule

// File: rtl/hla_cla_group.sv
module hla_cla_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          c_i,
  output logic [GW-1:0] s_o,
  output logic          c_o
);
  logic [GW-1:0] gen, prop, hsum;
  logic [GW:0]   cy;

  // flat sum-of-products per carry: no ripple inside the group
  function automatic logic [GW:0] la_carries(input logic [GW-1:0] g,
                                             input logic [GW-1:0] p,
                                             input logic          ci);
    logic [GW:0] c;
    logic        term;
    c    = '0;
    c[0] = ci;
    for (int k = 1; k <= int'(GW); k++) begin
      term = ci;
      for (int j = 0; j < k; j++) term = term & p[j];
      c[k] = term;
      for (int i = 0; i < k; i++) begin
        term = g[i];
        for (int j = i + 1; j < k; j++) term = term & p[j];
        c[k] = c[k] | term;
      end
    end
    return c;
  endfunction

  assign gen  = a_i & b_i;
  assign prop = a_i | b_i;
  assign hsum = a_i ^ b_i;
  assign cy   = la_carries(gen, prop, c_i);
  assign s_o  = hsum ^ cy[GW-1:0];
  assign c_o  = cy[GW];

  // R1
  always_comb begin
    grp_sum_chk: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {{GW{1'b0}}, c_i}))
      else $error("group sum mismatch");
  end
endmodule

// File: rtl/hla_flag_unit.sv
module hla_flag_unit import hla_pkg::*; #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         c_out_i,
  input  logic         c_msb_i,
  input  logic         sub_i,
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  output flags_t       flags_o
);
  localparam int unsigned MSB = W - 1;

  assign flags_o.zero  = ~|res_i;
  assign flags_o.neg   = res_i[MSB];
  assign flags_o.ovf_s = c_msb_i ^ c_out_i;
  assign flags_o.ovf_u = c_out_i ^ sub_i;

  // R5
  always_comb begin
    ovf_s_chk: assert (flags_o.ovf_s == ((a_msb_i == b_msb_i) && (res_i[MSB] != a_msb_i)))
      else $error("signed overflow mismatch");
  end
endmodule

// File: rtl/hla_addsub.sv
module hla_addsub import hla_pkg::*; #(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned GRP_W  = GRP_W_DEF
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_u_o,
  output logic              ovf_s_o,
  output logic              zero_o,
  output logic              neg_o
);
  localparam int unsigned NUM_GRP = DATA_W / GRP_W;
  localparam int unsigned MSB     = DATA_W - 1;

  logic [DATA_W-1:0]  q;
  logic [NUM_GRP:0]   c_grp;
  logic               c_msb_in;
  flags_t             flg;

  hla_opnd_mux #(.W(DATA_W)) u_mux (
    .y_i  (y_i),
    .inv_i(sub_i),
    .q_o  (q)
  );

  assign c_grp[0] = sub_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int unsigned HI = (g + 1) * GRP_W;
    logic [HI:0] ref_sum;

    hla_cla_group #(.GW(GRP_W)) u_grp (
      .a_i(x_i[g*GRP_W +: GRP_W]),
      .b_i(q[g*GRP_W +: GRP_W]),
      .c_i(c_grp[g]),
      .s_o(res_o[g*GRP_W +: GRP_W]),
      .c_o(c_grp[g+1])
    );

    assign ref_sum = {1'b0, x_i[HI-1:0]} + {1'b0, q[HI-1:0]} + {{HI{1'b0}}, sub_i};

    // R8
    always_comb begin
      grp_carry_chk: assert ({c_grp[g+1], res_o[HI-1:0]} == ref_sum)
        else $error("inter-group carry mismatch");
    end
  end

  // carry into the MSB recovered from its sum bit
  assign c_msb_in = x_i[MSB] ^ q[MSB] ^ res_o[MSB];

  hla_flag_unit #(.W(DATA_W)) u_flags (
    .res_i  (res_o),
    .c_out_i(c_grp[NUM_GRP]),
    .c_msb_i(c_msb_in),
    .sub_i  (sub_i),
    .a_msb_i(x_i[MSB]),
    .b_msb_i(q[MSB]),
    .flags_o(flg)
  );

  assign carry_o = c_grp[NUM_GRP];
  assign ovf_u_o = flg.ovf_u;
  assign ovf_s_o = flg.ovf_s;
  assign zero_o  = flg.zero;
  assign neg_o   = flg.neg;

  // R4
  always_comb begin
    ovf_u_chk: assert (ovf_u_o == (sub_i ? (x_i < y_i)
                                         : (({1'b0, x_i} + {1'b0, y_i}) > {1'b0, {DATA_W{1'b1}}})))
      else $error("unsigned overflow mismatch");
  end

  // R6
  always_comb begin
    zero_chk: assert (zero_o == (sub_i ? (x_i == y_i) : ((x_i + y_i) == '0)))
      else $error("zero flag mismatch");
  end
endmodule

// File: tb/hla_addsub_tb.sv
module hla_addsub_tb;
  localparam int unsigned W = 32;

  typedef struct {
    logic [W-1:0] x, y;
    logic         sub;
    logic [W-1:0] e_res;
    logic         e_c, e_ou, e_os, e_z, e_n;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] x, y, res;
  logic         sub, carry, ovf_u, ovf_s, zero, neg;
  item_t        exp_q[$];
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  hla_addsub u_dut (
    .x_i(x), .y_i(y), .sub_i(sub),
    .res_o(res), .carry_o(carry), .ovf_u_o(ovf_u),
    .ovf_s_o(ovf_s), .zero_o(zero), .neg_o(neg)
  );

  task automatic cmp(input string req, input string tag,
                     input logic [W-1:0] got, input logic [W-1:0] e);
    n_chk++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s (%s): got %h expected %h", req, tag, got, e);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input string tag);
    item_t        it;
    logic [W:0]   full;
    logic [W-1:0] bq;
    @(posedge clk);
    x   <= a;
    y   <= b;
    sub <= s;
    bq   = s ? ~b : b;
    full = {1'b0, a} + {1'b0, bq} + {{W{1'b0}}, s};
    it.x     = a;
    it.y     = b;
    it.sub   = s;
    it.e_res = full[W-1:0];
    it.e_c   = full[W];
    it.e_ou  = s ? (a < b) : full[W];
    it.e_os  = (a[W-1] == bq[W-1]) && (full[W-1] != a[W-1]);
    it.e_z   = (full[W-1:0] == '0);
    it.e_n   = full[W-1];
    it.tag   = tag;
    exp_q.push_back(it);
  endtask

  // monitor: combinational outputs settled by the falling edge
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      cmp(it.sub ? "R2" : "R1", it.tag, res, it.e_res);
      cmp("R3", it.tag, {{(W-1){1'b0}}, carry}, {{(W-1){1'b0}}, it.e_c});
      cmp("R4", it.tag, {{(W-1){1'b0}}, ovf_u}, {{(W-1){1'b0}}, it.e_ou});
      cmp("R5", it.tag, {{(W-1){1'b0}}, ovf_s}, {{(W-1){1'b0}}, it.e_os});
      cmp("R6", it.tag, {{(W-1){1'b0}}, zero},  {{(W-1){1'b0}}, it.e_z});
      cmp("R7", it.tag, {{(W-1){1'b0}}, neg},   {{(W-1){1'b0}}, it.e_n});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    x = '0; y = '0; sub = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(32'h0, 32'h0, 1'b0, "R6 idle zero operands");
    drive(32'd5, 32'd7, 1'b0, "R1 small add");
    drive(32'hFFFF_FFFF, 32'h1, 1'b0, "R8 full ripple wrap");
    drive(32'h0000_000F, 32'h1, 1'b0, "R8 first group boundary");
    drive(32'h00FF_FFFF, 32'h1, 1'b0, "R8 multi group carry");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R8 all propagate no carry");
    drive(32'hAAAA_AAAA, 32'h5555_5556, 1'b0, "R8 all propagate with carry");
    drive(32'h7FFF_FFFF, 32'h1, 1'b0, "R5 R7 positive overflow");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R5 R3 negative overflow");
    drive(32'd47, 32'd5, 1'b1, "R2 sub positive");
    drive(32'd5, 32'd47, 1'b1, "R4 R7 sub borrow");
    drive(32'h1234_5678, 32'h1234_5678, 1'b1, "R9 self subtract");
    drive(32'hDEAD_BEEF, 32'h0, 1'b1, "R9 subtract zero");
    drive(32'h8000_0000, 32'h1, 1'b1, "R5 sub underflow");
    drive(32'h0, 32'h8000_0000, 1'b1, "R5 negate min");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5 sub overflow");
    drive(32'h0, 32'h1, 1'b1, "R4 zero minus one");
    for (int i = 0; i < 400; i++) begin
      drive($urandom, $urandom, i[0], "R1 R2 random");
    end
    @(posedge clk);
    @(posedge clk);
    wait (exp_q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule